// File: doc/BRIEF.md
# Pipelined Burst SRAM Control Front-End

This block is the address and control path of a pipelined synchronous burst SRAM, wrapped around a small on-chip array. A burst starts on either of two active-low address strobes: one meant for a processor and one for a memory controller. On a start the external address is registered and a 2-bit beat counter is cleared. An active-low advance input then steps the counter one beat per clock. The beat order is linear or interleaved, picked by a static strap. The counter wraps inside an aligned block of four words and never carries into the upper address bits.

Every clock edge while the device is selected performs one access at the current burst address. With the write input low, that access stores the input word into the byte lanes whose enables are low. With the write input high, it reads the word into an output register. A read is therefore visible one clock after the edge that registered its address. Each lane carries a parity bit that is stored and returned like any other data bit. The data outputs are enabled only for a cycle that follows a read, only while the output enable is low, and only while the device is awake.

A sleep input freezes the block: strobes, writes and advances are ignored, the outputs go to high impedance, and the array and burst state are kept. Operation continues from the same burst position on the first clock after sleep falls.

Top module: `burst_sram_front`

## Requirements
- R1: A controller strobe (ctrlStrobeN low) with chipEnN low registers addrIn; a read at an edge drives the addressed word on dataOut, with dataOutEn high, during the cycle after that edge.
- R2: When both strobes are low with chipEnN low, the processor strobe wins: the access at that edge is a read whatever writeN is, and addrIn is captured as the new burst base.
- R3: A processor strobe while chipEnN is high is ignored: the burst address and the access at that edge are unchanged.
- R4: A controller strobe while chipEnN is high deselects the device. The access at that edge is suppressed, and later writes and reads are ignored until the next accepted strobe.
- R5: With burstMode low, the beat address low bits follow base+0, +1, +2, +3 modulo 4, and the upper address bits stay fixed.
- R6: With burstMode high, the beat address low bits are the base low bits XOR the beat count 0, 1, 2, 3.
- R7: advanceN low at a selected edge with no strobe moves to the next beat. advanceN high holds the current beat, so the same word is accessed again.
- R8: A write stores lane g (bits g*9+8 down to g*9, whose top bit is the parity bit) only when byteWeN[g] is low. Other lanes keep their contents.
- R9: In the cycle after a write edge, dataOutEn is low whatever outEnN is.
- R10: outEnN high forces dataOutEn low in the same cycle.
- R11: In the cycle after the strobe that selects a deselected device, dataOutEn is low, because no access happened at that edge.
- R12: While sleep is high, dataOutEn is low and strobes, writes and advances are ignored. Stored words and the burst position are kept, and accesses resume on the first edge after sleep falls.
- R13: After reset the device is deselected and dataOutEn is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything is sampled on its rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| addrIn | input | ADDR_W | Word address captured on an accepted strobe |
| procStrobeN | input | 1 | Processor address strobe, active low, has priority |
| ctrlStrobeN | input | 1 | Controller address strobe, active low |
| chipEnN | input | 1 | Chip enable, active low, qualifies both strobes |
| advanceN | input | 1 | Burst advance, active low |
| writeN | input | 1 | Write select for the access at this edge, active low |
| byteWeN | input | LANES | Per-lane write enables, active low |
| outEnN | input | 1 | Output enable, active low, combinational |
| sleep | input | 1 | Sleep request, active high |
| burstMode | input | 1 | Static strap: 0 linear order, 1 interleaved order |
| dataIn | input | LANES*LANE_W | Write word, parity bit on top of each lane |
| dataOut | output | LANES*LANE_W | Registered read word |
| dataOutEn | output | 1 | Output driver enable; high-impedance when low |

## Verification
The hardest state to reach from the pins is a strobe that must be ignored while a burst is in progress. Examples are a processor strobe under a deasserted chip enable, or any strobe during sleep. A wrongly accepted strobe changes nothing visible until a later read, so the bench first writes a known four-word block. It then points the ignored strobe at an address that was never written, or at a block holding different data. The following reads show whether the burst position moved. The interleaved order is exercised from a base whose low bits are 1, because from base 2 both orders produce the same sequence.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  // per-edge strobes from the control to the datapath
  typedef struct packed {
    logic access;   // an array access happens at this edge
    logic wrEn;     // that access is a write
    logic load;     // capture a new burst base
    logic advance;  // step to the next beat
  } ctl_t;
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_sram_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic procStrobeN,
  input  logic ctrlStrobeN,
  input  logic chipEnN,
  input  logic advanceN,
  input  logic writeN,
  input  logic sleep,
  output ctl_t ctl
);
  logic selected;
  logic procOk, ctrlHit, deselect, startAny, awake;

  always_comb begin
    awake    = !sleep;
    // processor strobe counts only under chip enable, and then wins (R2, R3)
    procOk   = !procStrobeN && !chipEnN;
    ctrlHit  = !ctrlStrobeN && !procOk;
    deselect = ctrlHit && chipEnN;                     // R4
    startAny = procOk || (ctrlHit && !chipEnN);
    ctl.access  = awake && selected && !deselect;
    ctl.wrEn    = ctl.access && !writeN && !procOk;
    ctl.load    = awake && startAny;
    ctl.advance = ctl.access && !advanceN && !startAny; // R7
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selected <= 1'b0;                                // R13
    end else if (awake) begin
      if (deselect)      selected <= 1'b0;
      else if (startAny) selected <= 1'b1;
    end
  end
endmodule

// File: rtl/burst_addr.sv
module burst_addr #(
  parameter int ADDR_W    = 6,
  parameter int BURST_LEN = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              burstMode,
  input  logic              load,
  input  logic              advance,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] curAddr
);
  localparam int LOW_W = $clog2(BURST_LEN);

  logic [ADDR_W-1:0] base;
  logic [LOW_W-1:0]  beat;
  logic [LOW_W-1:0]  lowBits;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      base <= '0;
      beat <= '0;
    end else if (load) begin
      base <= addrIn;
      beat <= '0;
    end else if (advance) begin
      beat <= beat + 1'b1;   // wraps inside the block
    end
  end

  // R5 linear, R6 interleaved; upper bits never carry
  always_comb begin
    if (burstMode) lowBits = base[LOW_W-1:0] ^ beat;
    else           lowBits = base[LOW_W-1:0] + beat;
    curAddr = {base[ADDR_W-1:LOW_W], lowBits};
  end
endmodule

// File: rtl/burst_data.sv
module burst_data
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctl_t                    ctl,
  input  logic                    burstMode,
  input  logic [ADDR_W-1:0]       addrIn,
  input  logic [LANES-1:0]        byteWeN,
  input  logic                    outEnN,
  input  logic                    sleep,
  input  logic [LANES*LANE_W-1:0] dataIn,
  output logic [LANES*LANE_W-1:0] dataOut,
  output logic                    dataOutEn
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] curAddr;
  logic              driveReg;

  burst_addr #(.ADDR_W(ADDR_W), .BURST_LEN(4)) addr_i (
    .clk      (clk),
    .rstN     (rstN),
    .burstMode(burstMode),
    .load     (ctl.load),
    .advance  (ctl.advance),
    .addrIn   (addrIn),
    .curAddr  (curAddr)
  );

  // one storage column and read register slice per lane; parity rides along (R8)
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] laneMem [DEPTH];
    logic [LANE_W-1:0] laneRd;

    always_ff @(posedge clk) begin
      if (ctl.wrEn && !byteWeN[g])
        laneMem[curAddr] <= dataIn[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
      if (!rstN)                        laneRd <= '0;
      else if (ctl.access && !ctl.wrEn) laneRd <= laneMem[curAddr];
    end

    assign dataOut[g*LANE_W +: LANE_W] = laneRd;
  end

  // drive only after a read edge (R1, R9, R11)
  always_ff @(posedge clk) begin
    if (!rstN) driveReg <= 1'b0;
    else       driveReg <= ctl.access && !ctl.wrEn;
  end

  assign dataOutEn = driveReg && !outEnN && !sleep;   // R10, R12
endmodule

// File: rtl/burst_sram_front.sv
module burst_sram_front
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       addrIn,
  input  logic                    procStrobeN,
  input  logic                    ctrlStrobeN,
  input  logic                    chipEnN,
  input  logic                    advanceN,
  input  logic                    writeN,
  input  logic [LANES-1:0]        byteWeN,
  input  logic                    outEnN,
  input  logic                    sleep,
  input  logic                    burstMode,
  input  logic [LANES*LANE_W-1:0] dataIn,
  output logic [LANES*LANE_W-1:0] dataOut,
  output logic                    dataOutEn
);
  ctl_t ctl;

  burst_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .procStrobeN(procStrobeN),
    .ctrlStrobeN(ctrlStrobeN),
    .chipEnN    (chipEnN),
    .advanceN   (advanceN),
    .writeN     (writeN),
    .sleep      (sleep),
    .ctl        (ctl)
  );

  burst_data #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) data_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .burstMode(burstMode),
    .addrIn   (addrIn),
    .byteWeN  (byteWeN),
    .outEnN   (outEnN),
    .sleep    (sleep),
    .dataIn   (dataIn),
    .dataOut  (dataOut),
    .dataOutEn(dataOutEn)
  );
endmodule

// File: rtl/burst_sram_front_chk.sv
module burst_sram_front_chk
  import burst_sram_pkg::*;
#(
  parameter int DW = 18
) (
  input logic          clk,
  input logic          rstN,
  input logic          procStrobeN,
  input logic          ctrlStrobeN,
  input logic          chipEnN,
  input logic          outEnN,
  input logic          sleep,
  input logic [DW-1:0] dataOut,
  input logic          dataOutEn,
  input ctl_t          ctl
);
  p_proc_prio_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!procStrobeN && !chipEnN && !sleep) |-> !ctl.wrEn);

  p_deselect_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlStrobeN && chipEnN && procStrobeN && !sleep) |=> !dataOutEn);

  p_write_hiz_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrEn |=> !dataOutEn);

  p_oe_off_r10: assert property (@(posedge clk) disable iff (!rstN)
    outEnN |-> !dataOutEn);

  p_sleep_hiz_r12: assert property (@(posedge clk) disable iff (!rstN)
    sleep |-> !dataOutEn);

  p_sleep_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    sleep |=> $stable(dataOut));
endmodule

bind burst_sram_front burst_sram_front_chk #(.DW(LANES*LANE_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .procStrobeN(procStrobeN),
  .ctrlStrobeN(ctrlStrobeN),
  .chipEnN    (chipEnN),
  .outEnN     (outEnN),
  .sleep      (sleep),
  .dataOut    (dataOut),
  .dataOutEn  (dataOutEn),
  .ctl        (ctl)
);

// File: tb/burst_sram_front_tb_top.sv
module burst_sram_front_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  addrIn = '0;
  logic        procStrobeN = 1'b1, ctrlStrobeN = 1'b1, chipEnN = 1'b0;
  logic        advanceN = 1'b1, writeN = 1'b1, outEnN = 1'b0, sleep = 1'b0;
  logic        burstMode = 1'b0;
  logic [1:0]  byteWeN = 2'b11;
  logic [17:0] dataIn = '0;
  logic [17:0] dataOut;
  logic        dataOutEn;

  int testsRun = 0;
  int testsFailed = 0;

  always #4 clk = ~clk;   // 125 MHz

  burst_sram_front dut_i (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .procStrobeN(procStrobeN),
    .ctrlStrobeN(ctrlStrobeN), .chipEnN(chipEnN), .advanceN(advanceN),
    .writeN(writeN), .byteWeN(byteWeN), .outEnN(outEnN), .sleep(sleep),
    .burstMode(burstMode), .dataIn(dataIn), .dataOut(dataOut),
    .dataOutEn(dataOutEn)
  );

  localparam logic [17:0] D0 = 18'h12345, D1 = 18'h0ABCD,
                          D2 = 18'h3C3C3, D3 = 18'h15A5A;
  localparam logic [17:0] M6 = 18'h123FF;   // D0 with lane 0 set to all ones

  // ctl bits: proc ctrl ce adv we bw1 bw0 oe sleep (all active low except sleep)
  typedef struct packed {
    logic [8:0]  ctl;
    logic [5:0]  addr;
    logic [17:0] din;
    logic        expEn;
    logic [17:0] expData;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VEC [NV] = '{
    '{9'b1_0_0_1_1_11_0_0, 6'd6,  18'h0,     1'b0, 18'h0, 4'd11}, // R11 start from deselect
    '{9'b1_1_0_0_0_00_0_0, 6'd0,  D0,        1'b0, 18'h0, 4'd9},  // R9 write beat 0
    '{9'b1_1_0_0_0_00_0_0, 6'd0,  D1,        1'b0, 18'h0, 4'd9},
    '{9'b1_1_0_0_0_00_0_0, 6'd0,  D2,        1'b0, 18'h0, 4'd9},
    '{9'b1_1_0_0_0_00_0_0, 6'd0,  D3,        1'b0, 18'h0, 4'd9},
    '{9'b1_0_0_1_1_11_0_0, 6'd6,  18'h0,     1'b1, D0,    4'd1},  // R1 restart, read 6
    '{9'b1_1_0_0_1_11_0_0, 6'd0,  18'h0,     1'b1, D0,    4'd1},  // R1 read base
    '{9'b1_1_0_0_1_11_0_0, 6'd0,  18'h0,     1'b1, D1,    4'd5},  // R5 addr 7
    '{9'b1_1_0_0_1_11_0_0, 6'd0,  18'h0,     1'b1, D2,    4'd5},  // R5 wrap to 4
    '{9'b1_1_0_0_1_11_0_0, 6'd0,  18'h0,     1'b1, D3,    4'd5},  // R5 addr 5
    '{9'b1_1_0_1_1_11_0_0, 6'd0,  18'h0,     1'b1, D0,    4'd7},  // R7 back at base, hold
    '{9'b1_1_0_1_1_11_0_0, 6'd0,  18'h0,     1'b1, D0,    4'd7},  // R7 held
    '{9'b1_1_0_1_1_11_1_0, 6'd0,  18'h0,     1'b0, 18'h0, 4'd10}, // R10 oe high
    '{9'b1_1_0_1_0_10_0_0, 6'd0,  18'h3FFFF, 1'b0, 18'h0, 4'd8},  // R8 lane 0 only
    '{9'b1_1_0_1_1_11_0_0, 6'd0,  18'h0,     1'b1, M6,    4'd8},  // R8 merged word
    '{9'b0_0_0_1_0_00_0_0, 6'd4,  18'h0,     1'b1, M6,    4'd2},  // R2 both strobes, no write
    '{9'b1_1_0_0_1_11_0_0, 6'd0,  18'h0,     1'b1, D2,    4'd2},  // R2 base 4 captured
    '{9'b1_1_0_0_1_11_0_0, 6'd0,  18'h0,     1'b1, D3,    4'd5},
    '{9'b0_1_1_1_1_11_0_0, 6'd60, 18'h0,     1'b1, M6,    4'd3},  // R3 proc under ce high
    '{9'b1_1_0_1_1_11_0_0, 6'd0,  18'h0,     1'b1, M6,    4'd3},  // R3 still at 6
    '{9'b1_0_1_1_1_11_0_0, 6'd0,  18'h0,     1'b0, 18'h0, 4'd4},  // R4 deselect
    '{9'b1_1_0_0_0_00_0_0, 6'd0,  18'h0,     1'b0, 18'h0, 4'd4},  // R4 write ignored
    '{9'b1_1_0_1_1_11_0_0, 6'd0,  18'h0,     1'b0, 18'h0, 4'd4},
    '{9'b1_0_0_1_1_11_0_0, 6'd6,  18'h0,     1'b0, 18'h0, 4'd11}, // R11
    '{9'b1_1_0_1_1_11_0_0, 6'd0,  18'h0,     1'b1, M6,    4'd4},  // R4 word intact
    '{9'b1_0_0_1_1_11_0_1, 6'd4,  18'h0,     1'b0, 18'h0, 4'd12}, // R12 strobe asleep
    '{9'b1_1_0_0_0_00_0_1, 6'd0,  18'h0,     1'b0, 18'h0, 4'd12}, // R12 write asleep
    '{9'b1_1_0_1_1_11_0_0, 6'd0,  18'h0,     1'b1, M6,    4'd12}, // R12 resumed at 6
    '{9'b1_1_0_0_1_11_0_0, 6'd0,  18'h0,     1'b1, M6,    4'd12}, // R12 beat not moved
    '{9'b1_1_0_0_1_11_0_0, 6'd0,  18'h0,     1'b1, D1,    4'd7}
  };

  task automatic drive(input logic [8:0] c, input logic [5:0] a, input logic [17:0] d);
    {procStrobeN, ctrlStrobeN, chipEnN, advanceN, writeN, byteWeN, outEnN, sleep} = c;
    addrIn = a;
    dataIn = d;
  endtask

  task automatic check(input string tag, input logic expEn, input logic [17:0] expData);
    logic bad;
    testsRun++;
    bad = (dataOutEn !== expEn) || (expEn && (dataOut !== expData));
    if (bad) begin
      testsFailed++;
      $display("FAIL %s: en=%b data=%h expected en=%b data=%h",
               tag, dataOutEn, dataOut, expEn, expData);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  initial begin
    repeat (200) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    drive(9'b1_1_0_1_1_11_0_0, 6'd0, 18'h0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R13", 1'b0, 18'h0);           // R13 during reset
    rstN = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R13", 1'b0, 18'h0);           // R13 after reset, idle

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].ctl, VEC[i].addr, VEC[i].din);
      @(posedge clk); @(negedge clk);
      check($sformatf("R%0d row %0d", VEC[i].req, i), VEC[i].expEn, VEC[i].expData);
    end

    // R6: interleaved order from base low bits 1: 5,4,7,6
    rstN = 1'b0;
    burstMode = 1'b1;
    drive(9'b1_1_0_1_1_11_0_0, 6'd0, 18'h0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    drive(9'b1_0_0_1_1_11_0_0, 6'd5, 18'h0);
    @(posedge clk); @(negedge clk);
    check("R13 R11", 1'b0, 18'h0);
    drive(9'b1_1_0_0_1_11_0_0, 6'd0, 18'h0);
    @(posedge clk); @(negedge clk);
    check("R6 beat0", 1'b1, D3);
    @(posedge clk); @(negedge clk);
    check("R6 beat1", 1'b1, D2);
    @(posedge clk); @(negedge clk);
    check("R6 beat2", 1'b1, D1);
    @(posedge clk); @(negedge clk);
    check("R6 beat3", 1'b1, M6);
    finish_run();
  end
endmodule